// File: doc/BRIEF.md
# Framebuffer pixel component extractor

This block turns one raw framebuffer pixel word into separate 8-bit red, green and blue values. A format register sets how many bytes of the incoming word belong to the pixel. Three select registers, one for each colour, set where that colour's bits start, how many bits it has, and a fallback value. Each cycle that a pixel word is presented, every colour field is extracted, widened to 8 bits by repeating its bits, and registered. A pixel outside the visible area, a buffer underrun, or a zero bit count makes the colour take its fallback value.

The block sits between a pixel fetch path and the display output stage. Configuration software writes the four registers through a simple write port while scan-out is stopped. A write takes effect for pixels presented in the cycle after the write. A typical setup is a 16-bit pixel with 5-6-5 fields, a 32-bit pixel with byte-wide fields, or a red fallback of 0xFF so that underruns show on screen.

Top module: `pix_unpack`

## Requirements
- R1: After reset, out_valid is 0, all three colour outputs are 0x00, every select register is zero and the format register selects one byte per pixel.
- R2: out_valid is pix_valid delayed by one clock. The colour outputs change only in the cycle after a valid pixel, and hold their value while pix_valid is low.
- R3: Register address 0 is the format register. Bits [4:3] of the written data hold bytes-per-pixel minus one, with 0 meaning one byte. Bits of pix_data at or above bytes-per-pixel times 8 read as zero.
- R4: Addresses 1, 2 and 3 are the red, green and blue select registers. In each of them, bits [4:0] give the lowest bit index, bits [11:8] give the bit count and bits [23:16] give the fallback value.
- R5: With a bit count of 8, a colour output equals pixel bits [lsb+7:lsb].
- R6: With a bit count n from 1 to 7, output bit 7-i equals field bit n-1-(i mod n) for i = 0..7. The field is left-aligned, and the bits below it repeat the field from its top bit down.
- R7: With a bit count n above 8, the output is the eight most significant bits of the n-bit field.
- R8: A colour whose bit count is 0 outputs its fallback value.
- R9: When pix_active is low, all three outputs take their fallback values.
- R10: When pix_underrun is high, all three outputs take their fallback values. This holds even when pix_active is high.
- R11: A register write is used for pixels presented from the next cycle on. A pixel presented in the same cycle as the write uses the old setting.
- R12: Field bits that lie above bit 31 of the pixel word read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 format, 1 red, 2 green, 3 blue |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_data | input | 32 | Raw pixel word |
| pix_active | input | 1 | Pixel lies inside the visible area |
| pix_underrun | input | 1 | Fetch buffer ran dry for this pixel |
| out_valid | output | 1 | Colour outputs updated from a pixel |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
The bench builds the block with its default four-byte pixel word, 5-bit lowest-index field and 4-bit count field. This reaches every format from one to four bytes, which lets the byte masking of R3 be seen for 1, 2 and 3 bytes. It also reaches bit counts up to 15, so fields wider than the output and fields that run past bit 31 can both be driven. Pixel words are chosen with distinct bit patterns so that a swapped channel, a wrong shift or a wrong fill pattern changes the expected byte.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
   // Output component width and select-field widths.
   localparam int CW        = 8;
   localparam int LSB_W     = 5;
   localparam int LEN_W     = 4;
   localparam int NUM_COMP  = 3;
   // Field positions inside register words (software-visible layout).
   localparam int SEL_LSB_POS = 0;
   localparam int SEL_LEN_POS = 8;
   localparam int SEL_DEF_POS = 16;
   localparam int FMT_POS     = 3;
   // Component order, also the register address minus one.
   localparam int C_RED   = 0;
   localparam int C_GREEN = 1;
   localparam int C_BLUE  = 2;

   typedef struct packed {
      logic [CW-1:0]    dflt;
      logic [LEN_W-1:0] len;
      logic [LSB_W-1:0] lsb;
   } comp_sel_t;
endpackage

// File: rtl/pxu_regs.sv
module pxu_regs
   import pxu_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 32,
   parameter int BPP_W  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [BPP_W-1:0]      bytes_m1,
   output comp_sel_t [NUM_COMP-1:0] sel
);
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   localparam logic [ADDR_W-1:0] FMT_ADDR = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bytes_m1 <= '0;
      end else if (wr_en && wr_addr == FMT_ADDR) begin
         bytes_m1 <= wr_data[FMT_POS +: BPP_W];
      end
   end

   for (genvar c = 0; c < NUM_COMP; c++) begin : g_sel
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(c + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel[c] <= '0;
         end else if (wr_en && wr_addr == MY_ADDR) begin
            sel[c].lsb  <= wr_data[SEL_LSB_POS +: LSB_W];
            sel[c].len  <= wr_data[SEL_LEN_POS +: LEN_W];
            sel[c].dflt <= wr_data[SEL_DEF_POS +: CW];
         end
      end
   end
endmodule

// File: rtl/pxu_mask.sv
module pxu_mask #(
   parameter int PIX_BYTES = 4,
   parameter int BPP_W     = 2
) (
   input  logic [PIX_BYTES*8-1:0] pix_in,
   input  logic [BPP_W-1:0]       bytes_m1,
   output logic [PIX_BYTES*8-1:0] pix_out
);
   for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
      localparam int unsigned BI = b;
      always_comb begin
         if (BI <= 32'(bytes_m1)) pix_out[b*8 +: 8] = pix_in[b*8 +: 8];
         else                     pix_out[b*8 +: 8] = 8'h00;
      end
   end
endmodule

// File: rtl/pxu_lane.sv
module pxu_lane
   import pxu_pkg::*;
#(
   parameter int PW = 32
) (
   input  logic [PW-1:0] word,
   input  comp_sel_t     sel,
   input  logic          force_dflt,
   output logic [CW-1:0] comp
);
   localparam int IDX_W = (PW > 1) ? $clog2(PW) : 1;

   logic [PW-1:0]    shifted;
   logic [CW-1:0]    ext;
   logic [IDX_W-1:0] idx;
   int               n;

   always_comb begin
      shifted = word >> sel.lsb;
      n       = int'(sel.len);
      ext     = '0;
      idx     = '0;
      if (n != 0) begin
         for (int i = 0; i < CW; i++) begin
            idx = IDX_W'(n - 1 - (i % n));
            ext[CW-1-i] = shifted[idx];
         end
      end
      if (force_dflt || n == 0) comp = sel.dflt;
      else                      comp = ext;
   end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pxu_pkg::*;
#(
   parameter int PIX_BYTES = 4,
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pix_valid,
   input  logic [PIX_BYTES*8-1:0] pix_data,
   input  logic              pix_active,
   input  logic              pix_underrun,
   output logic              out_valid,
   output logic [CW-1:0]     out_r,
   output logic [CW-1:0]     out_g,
   output logic [CW-1:0]     out_b
);
   localparam int PW    = PIX_BYTES * 8;
   localparam int BPP_W = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1;

   if (PIX_BYTES < 1 || PW > (1 << LSB_W)) begin : g_bad_bytes
      $error("pix_unpack: PIX_BYTES out of range for lsb field");
   end
   if (((1 << LEN_W) - 1) > PW) begin : g_bad_len
      $error("pix_unpack: bit count field exceeds pixel width");
   end
   if (DATA_W < SEL_DEF_POS + CW || DATA_W < FMT_POS + BPP_W) begin : g_bad_data
      $error("pix_unpack: write data too narrow for register fields");
   end
   if ((1 << ADDR_W) < NUM_COMP + 1) begin : g_bad_addr
      $error("pix_unpack: address too narrow for register count");
   end

   logic [BPP_W-1:0]         bytes_m1;
   comp_sel_t [NUM_COMP-1:0] sel_q;
   logic [PW-1:0]            pix_masked;
   logic                     force_dflt;
   logic [NUM_COMP-1:0][CW-1:0] comp_d;
   logic [NUM_COMP-1:0][CW-1:0] comp_q;

   pxu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BPP_W(BPP_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .bytes_m1 (bytes_m1),
      .sel      (sel_q)
   );

   pxu_mask #(.PIX_BYTES(PIX_BYTES), .BPP_W(BPP_W)) u_mask (
      .pix_in   (pix_data),
      .bytes_m1 (bytes_m1),
      .pix_out  (pix_masked)
   );

   assign force_dflt = !pix_active || pix_underrun;

   for (genvar c = 0; c < NUM_COMP; c++) begin : g_lane
      pxu_lane #(.PW(PW)) u_lane (
         .word       (pix_masked),
         .sel        (sel_q[c]),
         .force_dflt (force_dflt),
         .comp       (comp_d[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         comp_q    <= '0;
      end else begin
         out_valid <= pix_valid;
         if (pix_valid) comp_q <= comp_d;
      end
   end

   assign out_r = comp_q[C_RED];
   assign out_g = comp_q[C_GREEN];
   assign out_b = comp_q[C_BLUE];
endmodule

// File: rtl/pxu_chk.sv
module pxu_chk
   import pxu_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic pix_valid,
   input logic pix_active,
   input logic pix_underrun,
   input logic out_valid,
   input logic [CW-1:0] out_r,
   input logic [CW-1:0] out_g,
   input logic [CW-1:0] out_b,
   input comp_sel_t [NUM_COMP-1:0] sel_q
);
   // R2
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);
   // R2
   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);
   // R2
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
   // R9
   a_r9_inactive_default: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_active) |=>
         (out_r == $past(sel_q[C_RED].dflt) && out_g == $past(sel_q[C_GREEN].dflt)
          && out_b == $past(sel_q[C_BLUE].dflt)));
   // R10
   a_r10_underrun_default: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_underrun) |=>
         (out_r == $past(sel_q[C_RED].dflt) && out_g == $past(sel_q[C_GREEN].dflt)
          && out_b == $past(sel_q[C_BLUE].dflt)));
   // R8
   a_r8_red_len0: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && sel_q[C_RED].len == '0) |=> (out_r == $past(sel_q[C_RED].dflt)));
   // R8
   a_r8_green_len0: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && sel_q[C_GREEN].len == '0) |=> (out_g == $past(sel_q[C_GREEN].dflt)));
   // R8
   a_r8_blue_len0: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && sel_q[C_BLUE].len == '0) |=> (out_b == $past(sel_q[C_BLUE].dflt)));
endmodule

bind pix_unpack pxu_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pix_valid    (pix_valid),
   .pix_active   (pix_active),
   .pix_underrun (pix_underrun),
   .out_valid    (out_valid),
   .out_r        (out_r),
   .out_g        (out_g),
   .out_b        (out_b),
   .sel_q        (sel_q)
);

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pix_valid = 1'b0;
   logic [31:0] pix_data = '0;
   logic        pix_active = 1'b0;
   logic        pix_underrun = 1'b0;
   logic        out_valid;
   logic [7:0]  out_r, out_g, out_b;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   pix_unpack u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pix_valid(pix_valid), .pix_data(pix_data), .pix_active(pix_active),
      .pix_underrun(pix_underrun), .out_valid(out_valid),
      .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   typedef struct packed {
      logic [2:0]  nbytes;
      logic [31:0] rs, gs, bs;
      logic [31:0] pix;
      logic        act, und;
      logic [7:0]  er, eg, eb;
   } vec_t;

   // Select words: [23:16] fallback, [11:8] count, [4:0] lowest bit.
   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{3'd2, 32'h0000050B, 32'h00000605, 32'h00000500, 32'hFFFFA5C3, 1'b1, 1'b0, 8'hA5, 8'hBA, 8'h18}, // R6 R3
      '{3'd4, 32'h00EE0810, 32'h00EE0808, 32'h00EE0800, 32'h12345678, 1'b1, 1'b0, 8'h34, 8'h56, 8'h78}, // R5 R4
      '{3'd4, 32'h00110810, 32'h00220808, 32'h00330800, 32'h12345678, 1'b0, 1'b0, 8'h11, 8'h22, 8'h33}, // R9
      '{3'd4, 32'h00110810, 32'h00220808, 32'h00330800, 32'h12345678, 1'b1, 1'b1, 8'h11, 8'h22, 8'h33}, // R10
      '{3'd4, 32'h00000818, 32'h005A0000, 32'h00000800, 32'hCAFEBABE, 1'b1, 1'b0, 8'hCA, 8'h5A, 8'hBE}, // R8
      '{3'd1, 32'h00000800, 32'h00000808, 32'h00000404, 32'hFFFFFF9C, 1'b1, 1'b0, 8'h9C, 8'h00, 8'h99}, // R3
      '{3'd4, 32'h00000100, 32'h00000101, 32'h00000300, 32'h00000005, 1'b1, 1'b0, 8'hFF, 8'h00, 8'hB6}, // R6
      '{3'd4, 32'h00000C00, 32'h00000A04, 32'h0000081C, 32'hD0000ABC, 1'b1, 1'b0, 8'hAB, 8'h2A, 8'h0D}, // R7 R12
      '{3'd3, 32'h00000810, 32'h00000818, 32'h00000814, 32'hFF123456, 1'b1, 1'b0, 8'h12, 8'h00, 8'h01}  // R3
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send_pix(input logic [31:0] p, input logic act, input logic und);
      @(negedge clk);
      pix_valid = 1'b1; pix_data = p; pix_active = act; pix_underrun = und;
      @(negedge clk);
      pix_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid", {31'd0, out_valid}, 0);
      chk("R1 rgb", {8'd0, out_r, out_g, out_b}, 0);
      rst_n = 1'b1;
      // R1: zero select registers give zero fallbacks
      send_pix(32'hFFFFFFFF, 1'b1, 1'b0);
      chk("R1 valid after pixel", {31'd0, out_valid}, 1);
      chk("R1 default rgb", {8'd0, out_r, out_g, out_b}, 0);

      for (int v = 0; v < NV; v++) begin
         write_reg(2'd0, 32'(VEC[v].nbytes - 3'd1) << 3);
         write_reg(2'd1, VEC[v].rs);
         write_reg(2'd2, VEC[v].gs);
         write_reg(2'd3, VEC[v].bs);
         send_pix(VEC[v].pix, VEC[v].act, VEC[v].und);
         chk($sformatf("R4 vec%0d valid", v), {31'd0, out_valid}, 1);
         chk($sformatf("R5 vec%0d red", v),   {24'd0, out_r}, {24'd0, VEC[v].er});
         chk($sformatf("R5 vec%0d green", v), {24'd0, out_g}, {24'd0, VEC[v].eg});
         chk($sformatf("R5 vec%0d blue", v),  {24'd0, out_b}, {24'd0, VEC[v].eb});
      end

      // R2: idle cycle keeps outputs and drops valid (last vector left 12/00/01)
      @(negedge clk);
      pix_data = 32'h00FFFFFF; pix_active = 1'b1;
      @(negedge clk);
      chk("R2 idle valid", {31'd0, out_valid}, 0);
      chk("R2 hold rgb", {8'd0, out_r, out_g, out_b}, 32'h00120001);

      // R11: write in the same cycle as a pixel uses the old setting
      write_reg(2'd1, 32'h00110000);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h00770000;
      pix_valid = 1'b1; pix_data = 32'h0; pix_active = 1'b1; pix_underrun = 1'b0;
      @(negedge clk);
      wr_en = 1'b0; pix_valid = 1'b0;
      chk("R11 old setting", {24'd0, out_r}, 32'h11);
      send_pix(32'h0, 1'b1, 1'b0);
      chk("R11 new setting", {24'd0, out_r}, 32'h77);

      // R10: underrun also overrides inactive-area state
      send_pix(32'h12345678, 1'b0, 1'b1);
      chk("R10 both flags red", {24'd0, out_r}, 32'h77);

      // R1: asynchronous reset clears outputs again
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 re-reset rgb", {8'd0, out_r, out_g, out_b}, 0);
      chk("R1 re-reset valid", {31'd0, out_valid}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule